// File: doc/BRIEF.md
# Bang-Bang Frequency-Locked Loop Filter

This block is the digital filter of a bang-bang frequency-locked loop. On each comparison strobe it receives one decision bit from a chopped comparator and undoes the chopping inversion using the chop phase that came with that decision. It then moves a saturating oscillator tuning word (OTW) one code up or one code down. The OTW drives the digitally controlled oscillator directly.

The loop alternates between two reference resistors, one with a positive and one with a negative temperature coefficient. In the background the block keeps the settled tuning word of each resistor mode. The word is taken from the last strobe before the select flag leaves that mode, and a one-cycle valid pulse marks it. Downstream logic divides the two words to get a temperature reading in which the oscillator gain cancels out. Taking a capture never changes the OTW.

Top module: `dfll_loop_filter`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and after it is released, `otw` equals the parameter `RST_OTW` (default 2048), both captured words are 0 and both valid pulses are low.
- R2: On a cycle with `strobe`=1 the corrected decision is `cmp_bit` XOR `chop_ph`. A corrected 1 raises `otw` by one code and a corrected 0 lowers it by one. The new value appears at the output on the next rising clock edge.
- R3: On a cycle with `strobe`=0 and `reload`=0, `otw` keeps its value whatever `cmp_bit` and `chop_ph` are.
- R4: An upward decision at the maximum code (4095 for the default 12-bit width) leaves `otw` at the maximum code.
- R5: A downward decision at code 0 leaves `otw` at 0.
- R6: `reload`=1 loads `init_otw` into `otw` on the next edge. It takes priority over a strobe in the same cycle.
- R7: When `rsel_pos` changes and at least one strobe occurred in the mode being left, the OTW held before that edge is stored. Leaving mode 1 (positive-TC resistor) stores it in `otwp` and pulses `otwp_vld`. Leaving mode 0 stores it in `otwn` and pulses `otwn_vld`.
- R8: If a strobe falls in the same cycle as a change of `rsel_pos`, the stored word is the value before that strobe's update, and `otw` still takes the update.
- R9: A change of `rsel_pos` with no strobe since the last capture, reset or reload stores nothing and raises no valid pulse. A capture never alters `otw`.
- R10: Each valid pulse lasts one cycle, and `otwp_vld` and `otwn_vld` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reload | input | 1 | Synchronous load of `init_otw` into the tuning word |
| init_otw | input | OTW_W | Programmable start value for the tuning word |
| strobe | input | 1 | One pulse per comparison |
| cmp_bit | input | 1 | Raw comparator decision |
| chop_ph | input | 1 | Chop phase of this decision; 1 means inverted |
| rsel_pos | input | 1 | Resistor select: 1 = positive-TC, 0 = negative-TC |
| otw | output | OTW_W | Tuning word to the oscillator |
| otwp | output | OTW_W | Word stored for the positive-TC mode |
| otwp_vld | output | 1 | One-cycle pulse when `otwp` is updated |
| otwn | output | OTW_W | Word stored for the negative-TC mode |
| otwn_vld | output | 1 | One-cycle pulse when `otwn` is updated |

## Verification
A tuning step and a mode capture can fall in the same clock cycle. In that case the stored word must be the value from before the step, while the live word takes the step. The bench provokes this by raising `strobe` in the same cycle that `rsel_pos` flips, in both directions. It then checks that the captured word equals the pre-strobe value, that the matching valid pulse fires, and that `otw` has moved by one code on the same edge.

// File: rtl/dfll_lf_pkg.sv
package dfll_lf_pkg;
  localparam int unsigned OTW_W_DEF   = 12;
  localparam int unsigned NUM_MODES   = 2;

  typedef enum logic {
    MODE_NEG_TC = 1'b0,
    MODE_POS_TC = 1'b1
  } rmode_e;
endpackage

// File: rtl/dfll_rst_sync.sv
module dfll_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/dfll_chop_fix.sv
module dfll_chop_fix (
  input  logic cmp_bit,
  input  logic chop_ph,
  output logic dec_up
);
  // phase 1 means the comparator inputs were swapped for this decision
  always_comb dec_up = cmp_bit ^ chop_ph;
endmodule

// File: rtl/dfll_otw_accum.sv
module dfll_otw_accum #(
  parameter int unsigned W       = 12,
  parameter logic [W-1:0] RST_VAL = 12'd2048
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload,
  input  logic [W-1:0] init_val,
  input  logic         strobe,
  input  logic         dec_up,
  output logic [W-1:0] otw_q
);
  localparam logic [W-1:0] OTW_MAX = {W{1'b1}};
  localparam logic [W-1:0] OTW_MIN = '0;

  logic [W-1:0] otw_d;
  logic         otw_en;

  always_comb begin
    otw_d  = otw_q;
    otw_en = 1'b0;
    if (reload) begin
      otw_d  = init_val;
      otw_en = 1'b1;
    end else if (strobe) begin
      if (dec_up && (otw_q != OTW_MAX)) begin
        otw_d  = otw_q + 1'b1;
        otw_en = 1'b1;
      end else if (!dec_up && (otw_q != OTW_MIN)) begin
        otw_d  = otw_q - 1'b1;
        otw_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      otw_q <= RST_VAL;
    else if (otw_en) otw_q <= otw_d;
  end

  a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !reload && dec_up && otw_q != OTW_MAX) |=> (otw_q == $past(otw_q) + 1'b1));
  a_r2_step_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !reload && !dec_up && otw_q != OTW_MIN) |=> (otw_q == $past(otw_q) - 1'b1));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !reload) |=> $stable(otw_q));
  a_r4_sat_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !reload && dec_up && otw_q == OTW_MAX) |=> (otw_q == OTW_MAX));
  a_r5_sat_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !reload && !dec_up && otw_q == OTW_MIN) |=> (otw_q == OTW_MIN));
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (otw_q == $past(init_val)));
endmodule

// File: rtl/dfll_mode_capture.sv
module dfll_mode_capture
  import dfll_lf_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload,
  input  logic         strobe,
  input  logic         rsel,
  input  logic [W-1:0] otw_cur,
  output logic [W-1:0] cap_pos,
  output logic         vld_pos,
  output logic [W-1:0] cap_neg,
  output logic         vld_neg
);
  logic         rsel_q;
  logic         armed_q, armed_d;
  logic         change, take;
  logic [W-1:0] cap_q [NUM_MODES];
  logic         vld_q [NUM_MODES];

  always_comb begin
    change  = (rsel != rsel_q);
    take    = change && armed_q;
    armed_d = armed_q;
    if (reload)      armed_d = 1'b0;
    else if (strobe) armed_d = 1'b1;
    else if (take)   armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q  <= MODE_NEG_TC;
      armed_q <= 1'b0;
    end else begin
      rsel_q  <= rsel;
      armed_q <= armed_d;
    end
  end

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_slot
    logic slot_take;
    always_comb slot_take = take && (rsel_q == m[0]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_q[m] <= '0;
        vld_q[m] <= 1'b0;
      end else begin
        vld_q[m] <= slot_take;
        if (slot_take) cap_q[m] <= otw_cur;
      end
    end
  end

  assign cap_pos = cap_q[MODE_POS_TC];
  assign vld_pos = vld_q[MODE_POS_TC];
  assign cap_neg = cap_q[MODE_NEG_TC];
  assign vld_neg = vld_q[MODE_NEG_TC];

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vld_pos, vld_neg}));
  a_r10_pulse_p: assert property (@(posedge clk) disable iff (!rst_n)
    vld_pos |=> !vld_pos);
  a_r10_pulse_n: assert property (@(posedge clk) disable iff (!rst_n)
    vld_neg |=> !vld_neg);
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_pos && !vld_neg) |-> ($stable(cap_pos) && $stable(cap_neg)));
endmodule

// File: rtl/dfll_loop_filter.sv
module dfll_loop_filter
  import dfll_lf_pkg::*;
#(
  parameter int unsigned      OTW_W   = OTW_W_DEF,
  parameter logic [OTW_W-1:0] RST_OTW = OTW_W'(1 << (OTW_W - 1))
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [OTW_W-1:0] init_otw,
  input  logic             strobe,
  input  logic             cmp_bit,
  input  logic             chop_ph,
  input  logic             rsel_pos,
  output logic [OTW_W-1:0] otw,
  output logic [OTW_W-1:0] otwp,
  output logic             otwp_vld,
  output logic [OTW_W-1:0] otwn,
  output logic             otwn_vld
);
  logic rst_ns;
  logic dec_up;

  dfll_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  dfll_chop_fix u_chop (
    .cmp_bit (cmp_bit),
    .chop_ph (chop_ph),
    .dec_up  (dec_up)
  );

  dfll_otw_accum #(.W(OTW_W), .RST_VAL(RST_OTW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_ns),
    .reload   (reload),
    .init_val (init_otw),
    .strobe   (strobe),
    .dec_up   (dec_up),
    .otw_q    (otw)
  );

  dfll_mode_capture #(.W(OTW_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_ns),
    .reload  (reload),
    .strobe  (strobe),
    .rsel    (rsel_pos),
    .otw_cur (otw),
    .cap_pos (otwp),
    .vld_pos (otwp_vld),
    .cap_neg (otwn),
    .vld_neg (otwn_vld)
  );

  a_r7_pos_value: assert property (@(posedge clk) disable iff (!rst_ns)
    otwp_vld |-> (otwp == $past(otw)));
  a_r7_neg_value: assert property (@(posedge clk) disable iff (!rst_ns)
    otwn_vld |-> (otwn == $past(otw)));
  a_r9_no_disturb: assert property (@(posedge clk) disable iff (!rst_ns)
    ($past(!strobe) && $past(!reload) && (otwp_vld || otwn_vld)) |-> $stable(otw));
endmodule

// File: tb/sim_dfll_loop_filter.sv
module sim_dfll_loop_filter;
  localparam int W = 12;
  // vector: {strobe, cmp_bit, chop_ph, expected otw}
  localparam int NV = 10;
  localparam logic [W+2:0] VEC [NV] = '{
    {3'b110, 12'd2049}, {3'b111, 12'd2048}, {3'b100, 12'd2047},
    {3'b101, 12'd2048}, {3'b010, 12'd2048}, {3'b110, 12'd2049},
    {3'b110, 12'd2050}, {3'b001, 12'd2050}, {3'b101, 12'd2051},
    {3'b100, 12'd2050}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reload = 1'b0;
  logic [W-1:0] init_otw = '0;
  logic strobe = 1'b0, cmp_bit = 1'b0, chop_ph = 1'b0, rsel_pos = 1'b0;
  logic [W-1:0] otw, otwp, otwn;
  logic otwp_vld, otwn_vld;
  int errs = 0, checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dfll_loop_filter u0 (
    .clk(clk), .rst_n(rst_n), .reload(reload), .init_otw(init_otw),
    .strobe(strobe), .cmp_bit(cmp_bit), .chop_ph(chop_ph), .rsel_pos(rsel_pos),
    .otw(otw), .otwp(otwp), .otwp_vld(otwp_vld), .otwn(otwn), .otwn_vld(otwn_vld)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive for one cycle, then sample at the following falling edge
  task automatic cyc(input logic s, input logic c, input logic ch,
                     input logic rs, input logic rl, input logic [W-1:0] iv);
    strobe = s; cmp_bit = c; chop_ph = ch; rsel_pos = rs; reload = rl; init_otw = iv;
    @(negedge clk);
    strobe = 1'b0; reload = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 otw in reset", otw, 2048);
    chk("R1 otwp in reset", otwp, 0);
    chk("R1 otwn in reset", otwn, 0);
    chk("R1 valids in reset", {otwp_vld, otwn_vld}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 otw after release", otw, 2048);

    // R2 R3: table walk
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][W+2], VEC[i][W+1], VEC[i][W], 1'b0, 1'b0, '0);
      chk($sformatf("R2/R3 vector %0d otw", i), otw, VEC[i][W-1:0]);
      chk("R10 no valid during table", {otwp_vld, otwn_vld}, 0);
    end

    // R6: reload beats a simultaneous down strobe
    cyc(1, 0, 0, 0, 1, 12'd4093);
    chk("R6 reload priority", otw, 4093);
    // R4: saturate high
    cyc(1, 1, 0, 0, 0, '0); chk("R4 step to 4094", otw, 4094);
    cyc(1, 1, 0, 0, 0, '0); chk("R4 reach 4095", otw, 4095);
    cyc(1, 1, 0, 0, 0, '0); chk("R4 hold at max", otw, 4095);
    cyc(1, 0, 1, 0, 0, '0); chk("R4 chopped up at max", otw, 4095);
    // R5: saturate low
    cyc(0, 0, 0, 0, 1, 12'd1); chk("R6 reload to 1", otw, 1);
    cyc(1, 0, 0, 0, 0, '0); chk("R5 reach 0", otw, 0);
    cyc(1, 1, 1, 0, 0, '0); chk("R5 hold at 0", otw, 0);

    // R7: capture into otwn on leaving mode 0
    cyc(0, 0, 0, 0, 1, 12'd100);
    cyc(1, 1, 0, 0, 0, '0); chk("R7 setup otw", otw, 101);
    cyc(0, 0, 0, 1, 0, '0);
    chk("R7 otwn captured", otwn, 101);
    chk("R7 otwn_vld pulse", otwn_vld, 1);
    chk("R10 otwp_vld quiet", otwp_vld, 0);
    chk("R9 otw untouched by capture", otw, 101);
    cyc(0, 0, 0, 1, 0, '0);
    chk("R10 otwn_vld one cycle", otwn_vld, 0);

    // R9: leave mode 1 with no strobe in it
    cyc(0, 0, 0, 0, 0, '0);
    chk("R9 no otwp_vld", otwp_vld, 0);
    chk("R9 otwp unchanged", otwp, 0);
    chk("R9 otwn unchanged", otwn, 101);

    // R8: strobe in the same cycle as the change, both directions
    cyc(1, 1, 0, 0, 0, '0); chk("R8 setup otw", otw, 102);
    cyc(1, 1, 0, 1, 0, '0);
    chk("R8 otwn pre-step value", otwn, 102);
    chk("R8 otwn_vld", otwn_vld, 1);
    chk("R8 otw stepped", otw, 103);
    cyc(1, 0, 0, 1, 0, '0); chk("R8 otw in mode 1", otw, 102);
    cyc(1, 1, 1, 0, 0, '0);
    chk("R8 otwp pre-step value", otwp, 102);
    chk("R8 otwp_vld", otwp_vld, 1);
    chk("R8 otw stepped down", otw, 101);
    chk("R10 exclusive", otwn_vld, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule